// File: doc/BRIEF.md
# Status Byte Write-Protection Unit

This unit holds the protection status byte of a serial nonvolatile byte memory and decides, for every write, whether that write may go ahead. It keeps four pieces of state. The first is a write-enable latch. The second is a two-bit block-protect code that fences off a top fraction of the address space. The third is an enable bit that lets the external write-protect pin lock the status byte. The fourth is a copy of that pin, taken when each transaction starts.

The serial command decoder next to this unit sends it single-cycle strobes:
- the start and the end of a transaction (chip select falling and rising);
- set latch and clear latch;
- a write-class opcode accepted;
- a status-byte write carrying its data byte.

For any address presented, the unit returns a combinational allow for a memory byte write and a combinational allow for a status write. A byte that is not allowed is simply not stored by the decoder. The decoder still advances its address counter for that byte.

The nonvolatile bits are modelled as registers whose reset values are parameters.

Top module: `wp_guard`

## Requirements
- R1: After reset, status_o reads 00h and both mem_wr_ok_o and sr_wr_ok_o are 0.
- R2: status_o carries the enable bit at bit 7, the protect code at bits 3:2 (bit 3 high, bit 2 low) and the latch at bit 1. Bits 6:4 and bit 0 always read 0, even after a status write with those data bits set.
- R3: A set_wel_i pulse makes status_o[1] read 1 in the following cycle. A clr_wel_i pulse makes it read 0. When both arrive in the same cycle, the clear wins.
- R4: Bit 1 of a status write's data never changes the latch.
- R5: In a transaction in which wr_op_i pulsed, the latch stays set through any number of byte cycles. It reads 0 in the cycle after cs_rise_i.
- R6: With the latch set, mem_wr_ok_o is 0 exactly for the protected addresses: none for code 00, the top quarter (both address MSBs 1, 6000h–7FFFh) for 01, the top half (address MSB 1, 4000h–7FFFh) for 10, and every address for 11.
- R7: While the latch is 0, mem_wr_ok_o and sr_wr_ok_o are both 0 for every address.
- R8: sr_wr_ok_o equals latch AND NOT (enable AND sampled pin low). A status write made while sr_wr_ok_o is 0 leaves status_o unchanged. The pin never affects mem_wr_ok_o.
- R9: wp_n_i is sampled only on a cs_fall_i pulse; a change of the pin inside a transaction does not change sr_wr_ok_o until the next cs_fall_i.
- R10: A transaction without wr_op_i (for example one that only sets the latch) leaves the latch unchanged at cs_rise_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_fall_i | input | 1 | Pulse: transaction start, samples the pin |
| cs_rise_i | input | 1 | Pulse: transaction end |
| wp_n_i | input | 1 | Write-protect pin, active low |
| set_wel_i | input | 1 | Pulse: set the write-enable latch |
| clr_wel_i | input | 1 | Pulse: clear the write-enable latch |
| wr_op_i | input | 1 | Pulse: a memory or status write opcode was accepted |
| sr_wr_i | input | 1 | Pulse: status write with sr_wdata_i |
| sr_wdata_i | input | 8 | Status write data |
| addr_i | input | ADDR_W | Address to check for a memory write |
| mem_wr_ok_o | output | 1 | Memory write allowed at addr_i |
| sr_wr_ok_o | output | 1 | Status write allowed |
| status_o | output | 8 | Status byte |

## Verification
The bench builds the unit with its default parameters: a 15-bit address, and zero reset values for the protect code and the enable bit. With these defaults, the quarter and half boundaries fall at 6000h and 4000h, so the probes at 3FFFh/4000h, 5FFFh/6000h and at both ends of the space reach every edge of the protect table. Starting from an all-clear status byte, every protection tier has to be programmed through the same strobe sequences the decoder would issue. This exercises the latch auto-clear and the pin-sampling rules along the way.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int SR_W         = 8;
  localparam int SR_WPEN_BIT  = 7;
  localparam int SR_BP_HI_BIT = 3;
  localparam int SR_BP_LO_BIT = 2;
  localparam int SR_WEL_BIT   = 1;

  typedef enum logic [1:0] {
    BP_NONE    = 2'b00,
    BP_QUARTER = 2'b01,
    BP_HALF    = 2'b10,
    BP_ALL     = 2'b11
  } bp_code_t;

  function automatic logic [SR_W-1:0] pack_status(input logic wpen,
                                                  input logic [1:0] bp,
                                                  input logic wel);
    logic [SR_W-1:0] s;
    s = '0;
    s[SR_WPEN_BIT]  = wpen;
    s[SR_BP_HI_BIT] = bp[1];
    s[SR_BP_LO_BIT] = bp[0];
    s[SR_WEL_BIT]   = wel;
    return s;
  endfunction
endpackage

// File: rtl/wp_range_decode.sv
module wp_range_decode #(
  parameter int ADDR_W = 15
) (
  input  logic [1:0]        bp_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              prot_o
);
  import wp_pkg::*;
  localparam int TOP = ADDR_W - 1;

  logic upper_half, upper_quarter;

  generate
    if (ADDR_W >= 2) begin : g_wide
      assign upper_half    = addr_i[TOP];
      assign upper_quarter = addr_i[TOP] & addr_i[TOP-1];
    end else begin : g_narrow
      assign upper_half    = addr_i[TOP];
      assign upper_quarter = addr_i[TOP];
    end
  endgenerate

  always_comb begin
    unique case (bp_code_t'(bp_i))
      BP_NONE:    prot_o = 1'b0;
      BP_QUARTER: prot_o = upper_quarter;
      BP_HALF:    prot_o = upper_half;
      default:    prot_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/wp_wel_ctrl.sv
module wp_wel_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  input  logic wr_op_i,
  input  logic cs_rise_i,
  output logic wel_o
);
  logic wr_seen_q;
  logic end_clear;

  assign end_clear = cs_rise_i & (wr_seen_q | wr_op_i);

  always_ff @(posedge clk) begin
    if (rst)            wr_seen_q <= 1'b0;
    else if (cs_rise_i) wr_seen_q <= 1'b0;
    else if (wr_op_i)   wr_seen_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                      wel_o <= 1'b0;
    else if (clr_i || end_clear)  wel_o <= 1'b0;
    else if (set_i)               wel_o <= 1'b1;
  end
endmodule

// File: rtl/wp_nv_regs.sv
module wp_nv_regs #(
  parameter logic [1:0] BP_RST   = 2'b00,
  parameter logic       WPEN_RST = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_fall_i,
  input  logic       wp_n_i,
  input  logic       sr_wr_i,
  input  logic       sr_ok_i,
  input  logic [7:0] sr_wdata_i,
  output logic       wpen_o,
  output logic [1:0] bp_o,
  output logic       pin_hi_o
);
  import wp_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      wpen_o <= WPEN_RST;
      bp_o   <= BP_RST;
    end else if (sr_wr_i && sr_ok_i) begin
      wpen_o <= sr_wdata_i[SR_WPEN_BIT];
      bp_o   <= {sr_wdata_i[SR_BP_HI_BIT], sr_wdata_i[SR_BP_LO_BIT]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            pin_hi_o <= 1'b0;
    else if (cs_fall_i) pin_hi_o <= wp_n_i;
  end
endmodule

// File: rtl/wp_guard.sv
module wp_guard #(
  parameter int         ADDR_W   = 15,
  parameter logic [1:0] BP_RST   = 2'b00,
  parameter logic       WPEN_RST = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_fall_i,
  input  logic              cs_rise_i,
  input  logic              wp_n_i,
  input  logic              set_wel_i,
  input  logic              clr_wel_i,
  input  logic              wr_op_i,
  input  logic              sr_wr_i,
  input  logic [7:0]        sr_wdata_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              mem_wr_ok_o,
  output logic              sr_wr_ok_o,
  output logic [7:0]        status_o
);
  import wp_pkg::*;

  logic       wel, wpen, pin_hi, prot;
  logic [1:0] bp;

  wp_wel_ctrl u_wel (
    .clk(clk), .rst(rst), .set_i(set_wel_i), .clr_i(clr_wel_i),
    .wr_op_i(wr_op_i), .cs_rise_i(cs_rise_i), .wel_o(wel)
  );

  wp_nv_regs #(.BP_RST(BP_RST), .WPEN_RST(WPEN_RST)) u_nv (
    .clk(clk), .rst(rst), .cs_fall_i(cs_fall_i), .wp_n_i(wp_n_i),
    .sr_wr_i(sr_wr_i), .sr_ok_i(sr_wr_ok_o), .sr_wdata_i(sr_wdata_i),
    .wpen_o(wpen), .bp_o(bp), .pin_hi_o(pin_hi)
  );

  wp_range_decode #(.ADDR_W(ADDR_W)) u_rng (
    .bp_i(bp), .addr_i(addr_i), .prot_o(prot)
  );

  assign sr_wr_ok_o  = wel & ~(wpen & ~pin_hi);
  assign mem_wr_ok_o = wel & ~prot;
  assign status_o    = pack_status(wpen, bp, wel);
endmodule

// File: rtl/wp_guard_chk.sv
module wp_guard_chk #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_rise_i,
  input logic              set_wel_i,
  input logic              clr_wel_i,
  input logic              sr_wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              mem_wr_ok_o,
  input logic              sr_wr_ok_o,
  input logic [7:0]        status_o
);
  // R2: fixed bits stay zero
  assert_fixed_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (status_o & 8'h71) == 8'h00);

  // R3: clear strobe drops the latch
  assert_wel_clear_R3: assert property (@(posedge clk) disable iff (rst)
    clr_wel_i |=> !status_o[1]);

  // R3: set strobe alone raises the latch
  assert_wel_set_R3: assert property (@(posedge clk) disable iff (rst)
    (set_wel_i && !clr_wel_i && !cs_rise_i) |=> status_o[1]);

  // R7: no latch, no write of any kind
  assert_no_latch_block_R7: assert property (@(posedge clk) disable iff (rst)
    !status_o[1] |-> (!mem_wr_ok_o && !sr_wr_ok_o));

  // R6: full protection blocks every address
  assert_all_blocked_R6: assert property (@(posedge clk) disable iff (rst)
    (status_o[3:2] == 2'b11) |-> !mem_wr_ok_o);

  // R6: no protection with latch set allows every address
  assert_none_open_R6: assert property (@(posedge clk) disable iff (rst)
    (status_o[3:2] == 2'b00 && status_o[1]) |-> mem_wr_ok_o);

  // R8: a refused status write changes no stored protection bit
  assert_refused_sr_R8: assert property (@(posedge clk) disable iff (rst)
    (sr_wr_i && !sr_wr_ok_o) |=> ($stable(status_o[7]) && $stable(status_o[3:2])));
endmodule

bind wp_guard wp_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .cs_rise_i(cs_rise_i), .set_wel_i(set_wel_i),
  .clr_wel_i(clr_wel_i), .sr_wr_i(sr_wr_i), .addr_i(addr_i),
  .mem_wr_ok_o(mem_wr_ok_o), .sr_wr_ok_o(sr_wr_ok_o), .status_o(status_o)
);

// File: tb/tb_wp_guard.sv
`timescale 1ns/1ps
module tb_wp_guard;
  localparam int AW = 15;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_fall = 0, cs_rise = 0, wp_n = 1, set_wel = 0, clr_wel = 0;
  logic wr_op = 0, sr_wr = 0;
  logic [7:0] sr_wdata = 8'h00;
  logic [AW-1:0] addr = '0;
  logic mem_ok, sr_ok;
  logic [7:0] status;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #4 clk = ~clk;

  wp_guard #(.ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .cs_fall_i(cs_fall), .cs_rise_i(cs_rise),
    .wp_n_i(wp_n), .set_wel_i(set_wel), .clr_wel_i(clr_wel), .wr_op_i(wr_op),
    .sr_wr_i(sr_wr), .sr_wdata_i(sr_wdata), .addr_i(addr),
    .mem_wr_ok_o(mem_ok), .sr_wr_ok_o(sr_ok), .status_o(status)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic cs_start(input logic pin);
    tick(); wp_n = pin; cs_fall = 1;
    tick(); cs_fall = 0;
  endtask

  task automatic cs_end();
    tick(); cs_rise = 1;
    tick(); cs_rise = 0;
  endtask

  task automatic pulse_set();
    tick(); set_wel = 1;
    tick(); set_wel = 0;
  endtask

  task automatic do_wren();
    cs_start(1'b1); pulse_set(); cs_end();
  endtask

  task automatic do_wrsr(input logic [7:0] d, input logic pin);
    cs_start(pin);
    tick(); wr_op = 1; sr_wr = 1; sr_wdata = d;
    tick(); wr_op = 0; sr_wr = 0;
    cs_end();
  endtask

  function automatic logic exp_prot(input logic [1:0] bp, input logic [15:0] a);
    return (bp == 2'b11) || (bp == 2'b10 && a >= 16'h4000) ||
           (bp == 2'b01 && a >= 16'h6000);
  endfunction

  task automatic t_reset();
    #1;
    chk("R1 status", {8'h0, status}, 16'h0000);
    chk("R1 mem_ok", {15'h0, mem_ok}, 16'h0);
    chk("R1 sr_ok", {15'h0, sr_ok}, 16'h0);
    addr = 15'h7FFF; #1;
    chk("R7 mem_ok latch clear", {15'h0, mem_ok}, 16'h0);
  endtask

  task automatic t_latch();
    pulse_set();
    chk("R3 set", {15'h0, status[1]}, 16'h1);
    tick(); clr_wel = 1; tick(); clr_wel = 0;
    chk("R3 clear", {15'h0, status[1]}, 16'h0);
    tick(); set_wel = 1; clr_wel = 1; tick(); set_wel = 0; clr_wel = 0;
    chk("R3 clear wins", {15'h0, status[1]}, 16'h0);
    do_wren();
    chk("R10 wren end keeps latch", {15'h0, status[1]}, 16'h1);
  endtask

  task automatic t_fixed_bits();
    cs_start(1'b1);
    tick(); wr_op = 1; sr_wr = 1; sr_wdata = 8'hFF;
    tick(); wr_op = 0; sr_wr = 0;
    chk("R2 layout after FFh", {8'h0, status}, 16'h008E);
    cs_end();
    chk("R5 latch cleared at end", {8'h0, status}, 16'h008C);
    do_wren();
    cs_start(1'b1);
    tick(); wr_op = 1; sr_wr = 1; sr_wdata = 8'h00;
    tick(); wr_op = 0; sr_wr = 0;
    chk("R4 data bit1=0 keeps latch", {8'h0, status}, 16'h0002);
    cs_end();
    chk("R5 status after end", {8'h0, status}, 16'h0000);
    sr_wdata = 8'h02;
    do_wrsr(8'h02, 1'b1);
    chk("R4 data bit1=1 without latch", {8'h0, status}, 16'h0000);
    chk("R7 sr_ok latch clear", {15'h0, sr_ok}, 16'h0);
  endtask

  task automatic t_ranges();
    logic [15:0] probes [6] = '{16'h0000, 16'h3FFF, 16'h4000, 16'h5FFF, 16'h6000, 16'h7FFF};
    for (int b = 0; b < 4; b++) begin
      do_wren();
      do_wrsr({4'h0, b[1:0], 2'b00}, 1'b1);
      chk("R6 code stored", {14'h0, status[3:2]}, {14'h0, b[1:0]});
      do_wren();
      for (int i = 0; i < 6; i++) begin
        addr = probes[i][AW-1:0]; #1;
        chk("R6 range", {15'h0, mem_ok}, {15'h0, !exp_prot(b[1:0], probes[i])});
      end
    end
    clr_wel = 1; tick(); clr_wel = 0;
    do_wren(); do_wrsr(8'h00, 1'b1);
  endtask

  task automatic t_multi_byte();
    do_wren();
    cs_start(1'b1);
    tick(); wr_op = 1; tick(); wr_op = 0;
    for (int i = 0; i < 5; i++) begin
      addr = AW'(16'h1230 + i); tick();
      chk("R5 latch held mid write", {15'h0, mem_ok}, 16'h1);
    end
    cs_end();
    chk("R5 latch after end", {15'h0, status[1]}, 16'h0);
  endtask

  task automatic t_pin();
    do_wren(); do_wrsr(8'h80, 1'b0);
    chk("R8 enable bit set, pin ignored while enable clear", {8'h0, status}, 16'h0080);
    do_wren();
    cs_start(1'b0);
    addr = 15'h0010; #1;
    chk("R8 sr locked", {15'h0, sr_ok}, 16'h0);
    chk("R8 memory unaffected by pin", {15'h0, mem_ok}, 16'h1);
    tick(); wr_op = 1; sr_wr = 1; sr_wdata = 8'h0C;
    tick(); wr_op = 0; sr_wr = 0;
    chk("R8 refused write", {8'h0, status}, 16'h0082);
    wp_n = 1'b1; tick(); tick();
    chk("R9 pin rise mid transaction", {15'h0, sr_ok}, 16'h0);
    cs_end();
    do_wren();
    cs_start(1'b1);
    chk("R8 sr open with pin high", {15'h0, sr_ok}, 16'h1);
    wp_n = 1'b0; tick(); tick();
    chk("R9 pin fall mid transaction", {15'h0, sr_ok}, 16'h1);
    tick(); wr_op = 1; sr_wr = 1; sr_wdata = 8'h00;
    tick(); wr_op = 0; sr_wr = 0;
    cs_end();
    chk("R8 write accepted", {8'h0, status}, 16'h0000);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst = 0;
    tick();
    t_reset();
    t_latch();
    t_fixed_bits();
    t_ranges();
    t_multi_byte();
    t_pin();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule